// File: doc/BRIEF.md
# Managed-flash write data receiver

This block sits on the device side of a parallel flash-card data bus and receives one write block at a time. The bus can use 1, 4 or 8 data lines, in single or dual data rate. Each data line already arrives as two samples per clock: one captured on the rising edge and one on the falling edge. The receiver waits for a start bit. It then gathers a fixed-size payload and the CRC16 check words of every active line, and checks the end bit. Last, it sends a 3-bit status token back on line 0.

The payload is held in an internal block buffer until the verdict is known. When the block is good, a one-cycle commit pulse marks it and the bytes leave in order on a valid/ready byte port. When the block is bad, a one-cycle drop pulse marks it and the buffer contents are never presented. The host must not start the next block until the current one has drained.

Top module: `mfw_wr_rx`

## Requirements
- R1: The block is idle until, with no drain pending, every active line reads 0 in the rising-edge sample. That cycle is the start bit. `cfg_width` and `cfg_ddr` are captured in that cycle and held for the whole block, and neither output port moves during reception.
- R2: The width code is 0 for one line, 1 for four lines and 2 for eight lines. The reserved code 3 means one line. Within a byte on its stream, earlier cycles carry higher bits. With four or eight lines, the highest-numbered active line carries the most significant bit of each group.
- R3: In single rate, every line moves one bit per cycle on the rising-edge sample. The payload is BLOCK_BYTES bytes, and 16 CRC bits per line follow it.
- R4: In dual rate, the rising-edge sample carries the even-numbered bytes (0, 2, 4, ...) and the falling-edge sample carries the odd-numbered bytes. Each line has its own CRC16 per edge. Both CRCs arrive in the same 16 cycles after the data.
- R5: Each CRC uses polynomial 0x1021 (x^16+x^12+x^5+1) with initial value 0. It is sent most significant bit first.
- R6: On `dat0_out`, the status token starts two cycles after the end-bit cycle E. Cycles E+2 to E+6 carry 0, s2, s1, s0, 1. `dat0_oe` is high in exactly those five cycles.
- R7: Status 010 is sent only when every active CRC matches. Any mismatch, on either edge, yields status 101.
- R8: A 0 in the end-bit cycle on any active line yields status 101, even when every CRC matches.
- R9: In the cycle after the end bit, exactly one of `blk_commit` (good block) or `blk_drop` (bad block) pulses for one cycle.
- R10: A committed block's bytes are presented in received order from cycle E+1. `wr_byte` holds steady while `wr_valid` is high and `wr_ready` is low.
- R11: A dropped block presents no bytes at all.
- R12: Lines above the selected width, and the falling-edge samples in single rate, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 2 | Line count code (0:1, 1:4, 2:8, 3:1) |
| cfg_ddr | input | 1 | 1 selects dual data rate |
| dat_rise | input | 8 | Data lines sampled on the rising edge |
| dat_fall | input | 8 | Data lines sampled on the falling edge |
| dat0_out | output | 1 | Status token value for line 0 |
| dat0_oe | output | 1 | Drive enable for line 0 |
| wr_valid | output | 1 | A committed byte is available |
| wr_byte | output | 8 | Committed byte |
| wr_ready | input | 1 | Downstream accepts the byte |
| blk_commit | output | 1 | One-cycle pulse: block accepted |
| blk_drop | output | 1 | One-cycle pulse: block discarded |

## Verification
The hardest case to reach from the ports is a dual-rate block in which only the odd-byte CRC of one line is wrong. In that block the even-byte CRCs and the end bits are all correct, so only the falling-edge checker can see the error. The bench builds its line streams per edge from a behavioural byte-to-line mapping and computes each CRC16 on its own. It then flips a single bit on one chosen edge and line, either in the payload or inside a CRC word. A second set of blocks leaves the CRCs intact and pulls one end bit low, which separates the end-bit check from the CRC check.

// File: rtl/mfw_pkg.sv
package mfw_pkg;

    localparam int unsigned DAT_LINES = 8;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam int unsigned CRC_BITS  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC,
        ST_ENDB,
        ST_GAP,
        ST_STAT
    } rx_state_e;

    // one serial CRC16 step, message bit in, MSB-first
    function automatic logic [15:0] crc16_step(logic [15:0] c, logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

    function automatic logic [DAT_LINES-1:0] lane_mask(logic [1:0] sel);
        case (sel)
            2'd1:    return 8'h0F;
            2'd2:    return 8'hFF;
            default: return 8'h01;
        endcase
    endfunction

    // last phase index of one byte on one stream
    function automatic logic [2:0] phase_last(logic [1:0] sel);
        case (sel)
            2'd1:    return 3'd1;
            2'd2:    return 3'd0;
            default: return 3'd7;
        endcase
    endfunction

    // shift one sample group into the byte being assembled
    function automatic logic [7:0] pack_shift(logic [7:0] sh, logic [7:0] d, logic [1:0] sel);
        case (sel)
            2'd1:    return {sh[3:0], d[3:0]};
            2'd2:    return d;
            default: return {sh[6:0], d[0]};
        endcase
    endfunction

endpackage

// File: rtl/mfw_crc_bank.sv
module mfw_crc_bank
    import mfw_pkg::*;
#(
    parameter int unsigned LINES = DAT_LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en_r,
    input  logic             en_f,
    input  logic [LINES-1:0] bits_r,
    input  logic [LINES-1:0] bits_f,
    input  logic [LINES-1:0] line_mask,
    input  logic             use_f,
    output logic             all_ok
);

    logic [LINES-1:0] lane_ok;

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        logic [15:0] cr_d, cr_q;
        logic [15:0] cf_d, cf_q;

        always_comb begin
            cr_d = cr_q;
            cf_d = cf_q;
            if (clear) begin
                cr_d = '0;
                cf_d = '0;
            end else begin
                if (en_r) cr_d = crc16_step(cr_q, bits_r[g]);
                if (en_f) cf_d = crc16_step(cf_q, bits_f[g]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cr_q <= '0;
                cf_q <= '0;
            end else begin
                cr_q <= cr_d;
                cf_q <= cf_d;
            end
        end

        // message followed by its own CRC leaves a zero remainder
        assign lane_ok[g] = !line_mask[g] || ((cr_q == 16'h0) && (!use_f || (cf_q == 16'h0)));
    end

    assign all_ok = &lane_ok;

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> all_ok);

endmodule

// File: rtl/mfw_blk_buf.sv
module mfw_blk_buf #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  logic [7:0]    wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [7:0]    wd1,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we0) mem_q[wa0] <= wd0;
        if (we1) mem_q[wa1] <= wd1;
    end

    assign rd = mem_q[ra];

endmodule

// File: rtl/mfw_wr_rx.sv
module mfw_wr_rx
    import mfw_pkg::*;
#(
    parameter int unsigned BLOCK_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_width,
    input  logic       cfg_ddr,
    input  logic [7:0] dat_rise,
    input  logic [7:0] dat_fall,
    output logic       dat0_out,
    output logic       dat0_oe,
    output logic       wr_valid,
    output logic [7:0] wr_byte,
    input  logic       wr_ready,
    output logic       blk_commit,
    output logic       blk_drop
);

    localparam int unsigned AW    = $clog2(BLOCK_BYTES);
    localparam int unsigned IDX_W = AW + 1;
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(BLOCK_BYTES);
    localparam logic [AW-1:0]    PTR_LAST = AW'(BLOCK_BYTES - 1);
    localparam logic [4:0]       CRC_LAST = 5'(CRC_BITS - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [1:0]       wsel;
        logic             ddr;
        logic [2:0]       ph;
        logic [IDX_W-1:0] idx;
        logic [4:0]       ccnt;
        logic [7:0]       sh_r;
        logic [7:0]       sh_f;
        logic [2:0]       tx_cnt;
        logic [2:0]       stat;
        logic             oe;
        logic             dout;
        logic             commit;
        logic             drop;
        logic             drain;
        logic [AW-1:0]    rptr;
    } rx_regs_t;

    rx_regs_t q, n;

    logic          crc_clear, crc_en_r, crc_en_f, crc_ok;
    logic          we0, we1;
    logic [AW-1:0] wa0, wa1;
    logic [7:0]    wd0, wd1;
    logic [7:0]    act_mask;
    logic          blk_good;

    assign act_mask = lane_mask(q.wsel);

    always_comb begin
        n         = q;
        n.commit  = 1'b0;
        n.drop    = 1'b0;
        crc_clear = 1'b0;
        crc_en_r  = 1'b0;
        crc_en_f  = 1'b0;
        we0       = 1'b0;
        we1       = 1'b0;
        wa0       = q.idx[AW-1:0];
        wa1       = q.idx[AW-1:0] + AW'(1);
        wd0       = '0;
        wd1       = '0;
        blk_good  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (!q.drain && ((dat_rise & lane_mask(cfg_width)) == 8'h00)) begin
                    n.st      = ST_DATA;
                    n.wsel    = cfg_width;
                    n.ddr     = cfg_ddr;
                    n.ph      = '0;
                    n.idx     = '0;
                    crc_clear = 1'b1;
                end
            end
            ST_DATA: begin
                crc_en_r = 1'b1;
                crc_en_f = q.ddr;
                n.sh_r   = pack_shift(q.sh_r, dat_rise, q.wsel);
                n.sh_f   = pack_shift(q.sh_f, dat_fall, q.wsel);
                if (q.ph == phase_last(q.wsel)) begin
                    n.ph = '0;
                    we0  = 1'b1;
                    wd0  = n.sh_r;
                    if (q.ddr) begin
                        we1   = 1'b1;
                        wd1   = n.sh_f;
                        n.idx = q.idx + IDX_W'(2);
                    end else begin
                        n.idx = q.idx + IDX_W'(1);
                    end
                    if (n.idx == IDX_END) begin
                        n.st   = ST_CRC;
                        n.ccnt = '0;
                    end
                end else begin
                    n.ph = q.ph + 3'd1;
                end
            end
            ST_CRC: begin
                crc_en_r = 1'b1;
                crc_en_f = q.ddr;
                n.ccnt   = q.ccnt + 5'd1;
                if (q.ccnt == CRC_LAST) n.st = ST_ENDB;
            end
            ST_ENDB: begin
                blk_good = crc_ok && ((dat_rise & act_mask) == act_mask);
                n.stat   = blk_good ? 3'b010 : 3'b101;
                n.commit = blk_good;
                n.drop   = !blk_good;
                n.drain  = blk_good;
                n.rptr   = '0;
                n.st     = ST_GAP;
            end
            ST_GAP: begin
                n.st     = ST_STAT;
                n.oe     = 1'b1;
                n.dout   = 1'b0;
                n.tx_cnt = '0;
            end
            ST_STAT: begin
                n.tx_cnt = q.tx_cnt + 3'd1;
                case (q.tx_cnt)
                    3'd0: n.dout = q.stat[2];
                    3'd1: n.dout = q.stat[1];
                    3'd2: n.dout = q.stat[0];
                    3'd3: n.dout = 1'b1;
                    default: begin
                        n.oe   = 1'b0;
                        n.dout = 1'b1;
                        n.st   = ST_IDLE;
                    end
                endcase
            end
            default: n.st = ST_IDLE;
        endcase

        if (q.drain && wr_ready) begin
            if (q.rptr == PTR_LAST) n.drain = 1'b0;
            else                    n.rptr  = q.rptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.dout <= 1'b1;
        end else begin
            q <= n;
        end
    end

    mfw_crc_bank #(.LINES(DAT_LINES)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (crc_clear),
        .en_r      (crc_en_r),
        .en_f      (crc_en_f),
        .bits_r    (dat_rise),
        .bits_f    (dat_fall),
        .line_mask (act_mask),
        .use_f     (q.ddr),
        .all_ok    (crc_ok)
    );

    mfw_blk_buf #(.DEPTH(BLOCK_BYTES), .AW(AW)) u_buf (
        .clk (clk),
        .we0 (we0),
        .wa0 (wa0),
        .wd0 (wd0),
        .we1 (we1),
        .wa1 (wa1),
        .wd1 (wd1),
        .ra  (q.rptr),
        .rd  (wr_byte)
    );

    assign dat0_out   = q.dout;
    assign dat0_oe    = q.oe;
    assign wr_valid   = q.drain;
    assign blk_commit = q.commit;
    assign blk_drop   = q.drop;

    assert_verdict_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_commit && blk_drop));

    assert_commit_presents_R10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_commit |-> wr_valid);

    assert_hold_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_byte)));

    assert_drop_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        blk_drop |-> !wr_valid);

    assert_token_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat0_oe) |-> !dat0_out);

    assert_token_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat0_oe) |-> $past(dat0_out));

    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_END);

    assert_no_write_in_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !(we0 || we1));

endmodule

// File: tb/sim_mfw_wr_rx.sv
module sim_mfw_wr_rx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_width;
    logic       cfg_ddr;
    logic [7:0] dat_rise;
    logic [7:0] dat_fall;
    logic       dat0_out, dat0_oe;
    logic       wr_valid;
    logic [7:0] wr_byte;
    logic       wr_ready;
    logic       blk_commit, blk_drop;

    always #10 clk = ~clk;

    mfw_wr_rx u0 (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_ddr(cfg_ddr),
        .dat_rise(dat_rise), .dat_fall(dat_fall), .dat0_out(dat0_out), .dat0_oe(dat0_oe),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_ready(wr_ready),
        .blk_commit(blk_commit), .blk_drop(blk_drop)
    );

    int nchk = 0;
    int nerr = 0;
    bit lb [0:1][0:7][0:4111];
    logic [7:0] blk [0:511];
    int ncyc;

    function automatic logic [15:0] ref_crc(logic [15:0] c, bit b);
        logic [15:0] r;
        r = c << 1;
        if (c[15] != b) r = r ^ 16'h1021;
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // lane streams from bytes: stream 0 = rising sample, stream 1 = falling sample
    task automatic build(int w, bit ddr, int seed);
        int per, p0, p1;
        logic [15:0] c;
        per = 8 / w;
        p0 = 0;
        p1 = 0;
        for (int k = 0; k < 512; k++)
            blk[k] = 8'((k * 29 + seed * 53 + (k >> 4)) ^ (seed << 3));
        for (int b = 0; b < 512; b++) begin
            for (int k = 0; k < per; k++) begin
                for (int i = 0; i < w; i++) begin
                    if (!ddr || (b % 2 == 0)) lb[0][i][p0] = blk[b][8 - (k + 1) * w + i];
                    else                      lb[1][i][p1] = blk[b][8 - (k + 1) * w + i];
                end
                if (!ddr || (b % 2 == 0)) p0++;
                else                      p1++;
            end
        end
        for (int s = 0; s < (ddr ? 2 : 1); s++) begin
            for (int i = 0; i < w; i++) begin
                c = 16'h0;
                for (int p = 0; p < p0; p++) c = ref_crc(c, lb[s][i][p]);
                for (int j = 0; j < 16; j++) lb[s][i][p0 + j] = c[15 - j];
            end
        end
        ncyc = p0 + 16;
    endtask

    task automatic run_block(string req, int w, logic [1:0] sel, bit ddr, int seed,
                             int fs, int fi, int fc, int bad_end, bit swap, bit exp_ok);
        int quiet, got, mism, seen;
        logic [2:0] st;
        build(w, ddr, seed);
        if (fs >= 0) lb[fs][fi][fc] = ~lb[fs][fi][fc];
        @(negedge clk);
        cfg_width = sel;
        cfg_ddr   = ddr;
        dat_rise  = 8'hFF;
        dat_fall  = 8'($urandom);
        @(negedge clk);
        for (int i = 0; i < 8; i++) dat_rise[i] = (i < w) ? 1'b0 : 1'($urandom);
        dat_fall = 8'($urandom);
        quiet = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (wr_valid || dat0_oe || blk_commit || blk_drop) quiet++;
            if (swap && c == 0) begin
                cfg_width = ~sel;
                cfg_ddr   = ~ddr;
            end
            for (int i = 0; i < 8; i++) begin
                dat_rise[i] = (i < w) ? lb[0][i][c] : 1'($urandom);
                dat_fall[i] = (i < w && ddr) ? lb[1][i][c] : 1'($urandom);
            end
        end
        @(negedge clk);
        if (wr_valid || dat0_oe || blk_commit || blk_drop) quiet++;
        for (int i = 0; i < 8; i++) dat_rise[i] = (i < w) ? (i != bad_end) : 1'($urandom);
        chk(quiet == 0, "R1", {req, " outputs quiet during reception"}, quiet, 0);
        // E+1
        @(negedge clk);
        dat_rise = 8'hFF;
        cfg_width = sel;
        cfg_ddr   = ddr;
        chk(blk_commit == exp_ok && blk_drop == !exp_ok, "R9",
            {req, " commit/drop verdict"}, {blk_commit, blk_drop}, {exp_ok, !exp_ok});
        chk(wr_valid == exp_ok && !dat0_oe, "R10",
            {req, " byte port at E+1"}, {wr_valid, dat0_oe}, {exp_ok, 1'b0});
        // E+2 start bit
        @(negedge clk);
        chk(dat0_oe && !dat0_out && !blk_commit && !blk_drop, "R6",
            {req, " token start and single pulse"},
            {dat0_oe, dat0_out, blk_commit, blk_drop}, 4'b1000);
        st = exp_ok ? 3'b010 : 3'b101;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(dat0_oe && dat0_out == st[2 - j], exp_ok ? "R7" : req,
                {req, " status bit"}, {dat0_oe, dat0_out}, {1'b1, st[2 - j]});
        end
        @(negedge clk);
        chk(dat0_oe && dat0_out, "R6", {req, " token end bit"}, {dat0_oe, dat0_out}, 2'b11);
        @(negedge clk);
        chk(!dat0_oe, "R6", {req, " line released"}, dat0_oe, 0);
        if (exp_ok) begin
            got = 0;
            mism = 0;
            for (int k = 0; k < 3000 && got < 512; k++) begin
                @(negedge clk);
                wr_ready = (k % 3 != 2);
                if (wr_valid && wr_ready) begin
                    if (wr_byte != blk[got]) begin
                        if (mism == 0)
                            $display("FAIL R10 %s byte %0d actual=%0d expected=%0d",
                                     req, got, wr_byte, blk[got]);
                        mism++;
                    end
                    got++;
                end
            end
            @(negedge clk);
            wr_ready = 1'b0;
            chk(got == 512 && mism == 0, "R10", {req, " bytes delivered in order"}, got, 512);
            chk(!wr_valid, "R10", {req, " drain finished"}, wr_valid, 0);
        end else begin
            seen = 0;
            wr_ready = 1'b1;
            repeat (600) begin
                @(negedge clk);
                if (wr_valid) seen++;
            end
            wr_ready = 1'b0;
            chk(seen == 0, "R11", {req, " no bytes from dropped block"}, seen, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cfg_width = 2'd0;
        cfg_ddr   = 1'b0;
        dat_rise  = 8'hFF;
        dat_fall  = 8'hFF;
        wr_ready  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dat0_oe && !wr_valid && !blk_commit && !blk_drop, "R9", "reset state",
            {dat0_oe, wr_valid, blk_commit, blk_drop}, 0);

        // good blocks, all widths and rates (R2 R3 R4 R5 R12)
        run_block("R3 sdr x1",  1, 2'd0, 1'b0, 1, -1, 0, 0, -1, 1'b0, 1'b1);
        run_block("R2 sdr x4",  4, 2'd1, 1'b0, 2, -1, 0, 0, -1, 1'b0, 1'b1);
        run_block("R12 sdr x8", 8, 2'd2, 1'b0, 3, -1, 0, 0, -1, 1'b0, 1'b1);
        run_block("R4 ddr x1",  1, 2'd0, 1'b1, 4, -1, 0, 0, -1, 1'b0, 1'b1);
        run_block("R5 ddr x4",  4, 2'd1, 1'b1, 5, -1, 0, 0, -1, 1'b0, 1'b1);
        run_block("R4 ddr x8",  8, 2'd2, 1'b1, 6, -1, 0, 0, -1, 1'b0, 1'b1);
        // odd-byte stream payload error on one line (R4 R7)
        run_block("R7 ddr odd-byte crc", 8, 2'd2, 1'b1, 7, 1, 5, 100, -1, 1'b0, 1'b0);
        // even-byte stream payload error
        run_block("R7 ddr even-byte crc", 4, 2'd1, 1'b1, 8, 0, 2, 37, -1, 1'b0, 1'b0);
        // error inside a CRC word
        run_block("R7 sdr crc word", 4, 2'd1, 1'b0, 9, 0, 3, 1024 + 9, -1, 1'b0, 1'b0);
        // missing end bit, CRCs intact
        run_block("R8 sdr end line7", 8, 2'd2, 1'b0, 10, -1, 0, 0, 7, 1'b0, 1'b0);
        run_block("R8 ddr end line0", 1, 2'd0, 1'b1, 11, -1, 0, 0, 0, 1'b0, 1'b0);
        // reserved width code acts as one line
        run_block("R2 reserved code", 1, 2'd3, 1'b0, 12, -1, 0, 0, -1, 1'b0, 1'b1);
        // config changes after start are ignored
        run_block("R1 cfg latched", 8, 2'd2, 1'b0, 13, -1, 0, 0, -1, 1'b1, 1'b1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule